// File: doc/BRIEF.md
# Two-Wire Serial Register Port

This block is a slave-only two-wire serial port that gives a host controller access to a bank of 16-bit control registers. Each register has an 8-bit index. The block oversamples the serial clock and data lines with its own system clock, and it detects start, repeated-start and stop conditions. It answers a fixed 7-bit device identity by pulling the data line low in the acknowledge slot, and it moves every byte most significant bit first.

A write transfer carries a register index byte and then one or more 16-bit words, each sent as a high byte followed by a low byte. A read transfer is a write transfer that carries only the index, then a repeated start with the direction bit set. The block returns words high byte first and keeps sending for as long as the host acknowledges. By default the register index advances after every word, and a mode bit can hold it fixed. A second mode bit refuses reads.

A clock-guard bit can block writes to all other registers while the system clock is reported absent. A write to the guard register itself always passes. Every accepted word appears for one cycle on a write strobe output. A small register file inside the block stores the written words and returns them for reads.

Top module: `twi_reg_slave`

## Requirements
- R1: After reset the data line is released (`sda_oe`=0) and `reg_we` is 0. Register 0x08 reads 0x0020, register 0x09 reads 0x0004, and every other register reads 0x0000.
- R2: After a start, the first byte is taken as a 7-bit identity plus a direction bit in bit 0 (1 = read). When the identity equals 7'b1001010 (write byte 0x94, read byte 0x95), the block drives the data line low during the ninth clock. Any other identity gets no acknowledge, and every later byte is ignored until the next start.
- R3: In a write transfer the block acknowledges the index byte and each data byte. Once the low byte of a word has been received, `reg_we` pulses for exactly one cycle, with `reg_waddr` set to the current index and `reg_wdata` set to {high byte, low byte}.
- R4: When bit 2 of register 0x09 is 1, the index increments by one (modulo 256) after each word is written or read, so consecutive words go to consecutive registers.
- R5: When bit 2 of register 0x09 is 0, the index stays fixed. Further written words go to the same register, and further read words come from it.
- R6: A read sends the high byte and then the low byte, MSB first. A host acknowledge after a byte continues the read. A host non-acknowledge ends the read, and the data line stays released until the next start.
- R7: When bit 0 of register 0x09 is 1, an identity byte with the direction bit at 1 gets no acknowledge and the block goes idle. Write transfers are still accepted.
- R8: When bit 5 of register 0x08 is 1 and `sysclk_ok` is 0, words aimed at any register other than 0x08 produce no strobe and change nothing. Words aimed at register 0x08 are always accepted. When that bit is 0, all words are accepted.
- R9: A stop or repeated start before a word's low byte discards the partial word. A repeated start keeps the index for a following read.
- R10: Registers 0x00 to 0x0F are stored. A write to any other index still produces the strobe but stores nothing, and a read of any other index returns 0x0000.
- R11: The block drives the data line only in acknowledge slots and read data bits. The drive changes only while the synchronised serial clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| sysclk_ok | input | 1 | 1 when the system clock is reported present |
| reg_we | output | 1 | One-cycle strobe for each accepted word |
| reg_waddr | output | 8 | Register index of the accepted word |
| reg_wdata | output | 16 | Value of the accepted word |

## Verification
The assertions assume that the host changes the data line only while the serial clock is low, except when it deliberately makes a start or stop. They also assume that each serial clock phase lasts longer than the synchroniser delay, and that `sysclk_ok` changes only between transfers. The bench drives every line change on the falling system clock edge. It holds each serial clock quarter-period for eight system clocks and makes its data moves in the middle of the low phase. It toggles `sysclk_ok` only while the bus is idle, so every stimulus stays inside those assumptions.

// File: rtl/twi_pkg.sv
`timescale 1ns/1ps
package twi_pkg;

    localparam int REG_AW = 8;
    localparam int REG_DW = 16;

    localparam logic [6:0] DEV_ADDR    = 7'b1001010;
    localparam logic [7:0] CTRL_REG    = 8'h08;
    localparam int         CLKEN_BIT   = 5;
    localparam logic [7:0] MODE_REG    = 8'h09;
    localparam int         AUTOINC_BIT = 2;
    localparam int         WRONLY_BIT  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_MACK
    } twi_state_e;

    typedef enum logic [1:0] {
        PH_REG,
        PH_HI,
        PH_LO
    } wr_phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] data;
    } reg_wr_t;

    function automatic logic [REG_DW-1:0] reset_value(input logic [REG_AW-1:0] a);
        logic [REG_DW-1:0] v;
        v = '0;
        if (a == CTRL_REG) v[CLKEN_BIT] = 1'b1;
        if (a == MODE_REG) v[AUTOINC_BIT] = 1'b1;
        return v;
    endfunction

    function automatic logic addr_ok(input logic [7:0] b, input logic [6:0] id,
                                     input logic wronly);
        return (b[7:1] == id) && !(b[0] && wronly);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
`timescale 1ns/1ps
module twi_line_sync
    import twi_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;
    logic              sda_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_now;
            sda_q    <= sda_now;
        end
    end

    assign scl_now = scl_pipe[STAGES-1];
    assign sda_now = sda_pipe[STAGES-1];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = !scl_q && scl_now;
        ev.scl_fall = scl_q && !scl_now;
        ev.start    = scl_q && scl_now && sda_q && !sda_now;
        ev.stop     = scl_q && scl_now && !sda_q && sda_now;
    end

endmodule

// File: rtl/twi_regfile.sv
`timescale 1ns/1ps
module twi_regfile
    import twi_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_wr_t           wr,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [REG_DW-1:0] rd_data,
    output logic              clk_gate_en,
    output logic              auto_inc,
    output logic              wr_only
);

    localparam int                IW       = $clog2(NUM_REGS);
    localparam logic [REG_AW-1:0] LAST     = REG_AW'(NUM_REGS - 1);
    localparam int                CTRL_IDX = int'(CTRL_REG);
    localparam int                MODE_IDX = int'(MODE_REG);

    logic [REG_DW-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= reset_value(REG_AW'(i));
            end
        end else if (wr.we && (wr.addr <= LAST)) begin
            regs[wr.addr[IW-1:0]] <= wr.data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == REG_AW'(i)) rd_data = regs[i];
        end
    end

    assign clk_gate_en = regs[CTRL_IDX][CLKEN_BIT];
    assign auto_inc    = regs[MODE_IDX][AUTOINC_BIT];
    assign wr_only     = regs[MODE_IDX][WRONLY_BIT];

endmodule

// File: rtl/twi_reg_slave.sv
`timescale 1ns/1ps
module twi_reg_slave
    import twi_pkg::*;
#(
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ID      = DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              sysclk_ok,
    output logic              reg_we,
    output logic [REG_AW-1:0] reg_waddr,
    output logic [REG_DW-1:0] reg_wdata
);

    line_ev_t          ev;
    twi_state_e        state;
    wr_phase_e         wphase;
    reg_wr_t           wr;
    logic [2:0]        bitcnt;
    logic [6:0]        shreg;
    logic [7:0]        byte_in;
    logic [6:0]        txb;
    logic [7:0]        hi_byte;
    logic [REG_AW-1:0] ptr;
    logic [REG_AW-1:0] ptr_next;
    logic [REG_AW-1:0] rd_addr;
    logic [REG_DW-1:0] rd_data;
    logic              rw;
    logic              ack_drv;
    logic              got_ack;
    logic              rd_lo;
    logic              wr_allowed;
    logic              clk_gate_en;
    logic              auto_inc;
    logic              wr_only;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twi_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .clk_gate_en (clk_gate_en),
        .auto_inc    (auto_inc),
        .wr_only     (wr_only)
    );

    always_comb begin
        byte_in    = {shreg, ev.sda};
        ptr_next   = auto_inc ? ptr + 1'b1 : ptr;
        rd_addr    = (state == ST_MACK && rd_lo) ? ptr_next : ptr;
        wr_allowed = (ptr == CTRL_REG) || !clk_gate_en || sysclk_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            wphase  <= PH_REG;
            wr      <= '0;
            bitcnt  <= '0;
            shreg   <= '0;
            txb     <= '0;
            hi_byte <= '0;
            ptr     <= '0;
            rw      <= 1'b0;
            ack_drv <= 1'b0;
            got_ack <= 1'b0;
            rd_lo   <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            wr.we <= 1'b0;
            if (ev.start) begin
                state   <= ST_ADDR;
                wphase  <= PH_REG;
                bitcnt  <= '0;
                ack_drv <= 1'b0;
                got_ack <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (ev.stop) begin
                state   <= ST_IDLE;
                ack_drv <= 1'b0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WR: begin
                        if (ev.scl_rise) begin
                            shreg  <= byte_in[6:0];
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                if (state == ST_ADDR) begin
                                    if (addr_ok(byte_in, DEV_ID, wr_only)) begin
                                        rw      <= byte_in[0];
                                        ack_drv <= 1'b0;
                                        state   <= ST_ACK;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end else begin
                                    state <= ST_ACK;
                                    case (wphase)
                                        PH_REG: begin
                                            ptr    <= byte_in;
                                            wphase <= PH_HI;
                                        end
                                        PH_HI: begin
                                            hi_byte <= byte_in;
                                            wphase  <= PH_LO;
                                        end
                                        default: begin
                                            wphase <= PH_HI;
                                            ptr    <= ptr_next;
                                            if (wr_allowed) begin
                                                wr.we   <= 1'b1;
                                                wr.addr <= ptr;
                                                wr.data <= {hi_byte, byte_in};
                                            end
                                        end
                                    endcase
                                end
                            end
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            if (!ack_drv) begin
                                ack_drv <= 1'b1;
                                sda_oe  <= 1'b1;
                            end else begin
                                ack_drv <= 1'b0;
                                bitcnt  <= '0;
                                if (rw) begin
                                    state  <= ST_RD;
                                    rd_lo  <= 1'b0;
                                    txb    <= rd_data[14:8];
                                    sda_oe <= !rd_data[15];
                                end else begin
                                    state  <= ST_WR;
                                    sda_oe <= 1'b0;
                                end
                            end
                        end
                    end
                    ST_RD: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                state   <= ST_MACK;
                                got_ack <= 1'b0;
                            end
                        end
                        if (ev.scl_fall) begin
                            txb    <= {txb[5:0], 1'b0};
                            sda_oe <= !txb[6];
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            if (ev.sda) state <= ST_IDLE;
                            else        got_ack <= 1'b1;
                        end
                        if (ev.scl_fall) begin
                            if (!got_ack) begin
                                sda_oe <= 1'b0;
                            end else begin
                                got_ack <= 1'b0;
                                bitcnt  <= '0;
                                state   <= ST_RD;
                                rd_lo   <= !rd_lo;
                                if (rd_lo) begin
                                    ptr    <= ptr_next;
                                    txb    <= rd_data[14:8];
                                    sda_oe <= !rd_data[15];
                                end else begin
                                    txb    <= rd_data[6:0];
                                    sda_oe <= !rd_data[7];
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_we    = wr.we;
    assign reg_waddr = wr.addr;
    assign reg_wdata = wr.data;

endmodule

// File: rtl/twi_reg_slave_chk.sv
`timescale 1ns/1ps
module twi_reg_slave_chk
    import twi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input line_ev_t          ev,
    input twi_state_e        state,
    input logic              sda_oe,
    input logic              reg_we,
    input logic [REG_AW-1:0] reg_waddr,
    input logic              sysclk_ok,
    input logic              clk_gate_en,
    input logic              wr_only
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && !reg_we));

    assert_ack_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(ev.scl_fall));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    assert_nack_ends_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MACK && ev.scl_rise && ev.sda) |=> (state == ST_IDLE));

    assert_stop_releases_R6: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (!sda_oe && state == ST_IDLE));

    assert_no_read_wronly_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD) |-> !wr_only);

    assert_clock_guard_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && clk_gate_en && !sysclk_ok) |-> (reg_waddr == CTRL_REG));

    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (state == ST_ADDR));

    assert_drive_states_R11: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ACK || state == ST_RD || state == ST_MACK));

    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !ev.scl);

endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ev          (ev),
    .state       (state),
    .sda_oe      (sda_oe),
    .reg_we      (reg_we),
    .reg_waddr   (reg_waddr),
    .sysclk_ok   (sysclk_ok),
    .clk_gate_en (clk_gate_en),
    .wr_only     (wr_only)
);

// File: tb/twi_reg_slave_tb.sv
`timescale 1ns/1ps
module twi_reg_slave_tb;

    localparam int Q        = 8;
    localparam int WATCHDOG = 180000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sysclk_ok = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic        reg_we;
    logic [7:0]  reg_waddr;
    logic [15:0] reg_wdata;

    int checks = 0;
    int errors = 0;

    logic [15:0] mdl [256];
    int          mptr = 0;
    logic [15:0] wbuf [8];

    logic [7:0]  exp_addr [$];
    logic [15:0] exp_data [$];
    string       exp_tag  [$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    twi_reg_slave u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .sysclk_ok (sysclk_ok),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // every clock: compare strobes against the model's expected write list
    always @(negedge clk) begin
        if (!rst && reg_we) begin
            if (exp_addr.size() == 0) begin
                check(1'b0, "R2/R8/R9", "unexpected strobe", {8'h0, reg_waddr, reg_wdata}, 32'h0);
            end else begin
                automatic logic [7:0]  ea = exp_addr.pop_front();
                automatic logic [15:0] ed = exp_data.pop_front();
                automatic string       et = exp_tag.pop_front();
                check(reg_waddr == ea && reg_wdata == ed, et, "strobe addr/data",
                      {8'h0, reg_waddr, reg_wdata}, {8'h0, ea, ed});
            end
        end
    end

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
        q();
    endtask

    task automatic clk_bit(input logic b, output logic s, output logic drv);
        sda_m = b; q();
        scl_m = 1'b1; q();
        s = sda_line;
        drv = sda_oe;
        q();
        scl_m = 1'b0; q();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked, output bit drove);
        logic s, d;
        drove = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i], s, d);
            if (d) drove = 1'b1;
        end
        clk_bit(1'b1, s, d);
        acked = (s == 1'b0);
    endtask

    task automatic read_byte(input logic nack, output logic [7:0] v);
        logic s, d;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s, d);
            v[i] = s;
        end
        clk_bit(nack, s, d);
    endtask

    task automatic send_checked(input logic [7:0] b, input bit exp_ack, input string tag);
        bit a, d;
        send_byte(b, a, d);
        check(a == exp_ack, tag, "acknowledge slot", {31'h0, a}, {31'h0, exp_ack});
        check(!d, "R11", "line driven during host data bits", {31'h0, d}, 32'h0);
    endtask

    task automatic write_words(input logic [7:0] ra, input int n, input string tag);
        bus_start();
        send_checked(8'h94, 1'b1, "R2");
        send_checked(ra, 1'b1, "R3");
        mptr = ra;
        for (int k = 0; k < n; k++) begin
            automatic bit acc = (mptr == 8) || !mdl[8][5] || sysclk_ok;
            automatic bit inc = mdl[9][2];
            if (acc) begin
                exp_addr.push_back(8'(mptr));
                exp_data.push_back(wbuf[k]);
                exp_tag.push_back(tag);
                if (mptr < 16) mdl[mptr] = wbuf[k];
            end
            send_checked(wbuf[k][15:8], 1'b1, "R3");
            send_checked(wbuf[k][7:0], 1'b1, "R3");
            if (inc) mptr = (mptr + 1) % 256;
        end
        bus_stop();
    endtask

    task automatic write_one(input logic [7:0] ra, input logic [15:0] w, input string tag);
        wbuf[0] = w;
        write_words(ra, 1, tag);
    endtask

    // from a repeated start onward; uses the model pointer
    task automatic read_cont(input int n, input string tag);
        logic [7:0] hi, lo;
        bus_start();
        send_checked(8'h95, 1'b1, "R2");
        for (int k = 0; k < n; k++) begin
            automatic logic [15:0] ew  = (mptr < 16) ? mdl[mptr] : 16'h0;
            automatic bit          inc = mdl[9][2];
            read_byte(1'b0, hi);
            read_byte(k == n - 1, lo);
            check({hi, lo} == ew, tag, $sformatf("read word %0d", k), {16'h0, hi, lo}, {16'h0, ew});
            if (inc) mptr = (mptr + 1) % 256;
        end
        check(sda_oe == 1'b0, "R6", "released after host NACK", {31'h0, sda_oe}, 32'h0);
        bus_stop();
        check(sda_oe == 1'b0, "R6", "released after stop", {31'h0, sda_oe}, 32'h0);
    endtask

    task automatic read_regs(input logic [7:0] ra, input int n, input string tag);
        bus_start();
        send_checked(8'h94, 1'b1, "R2");
        send_checked(ra, 1'b1, "R6");
        mptr = ra;
        read_cont(n, tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'h1, 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 16'h0;
        mdl[8] = 16'h0020;
        mdl[9] = 16'h0004;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", {31'h0, sda_oe}, 32'h0);
        check(reg_we == 1'b0, "R1", "reg_we after reset", {31'h0, reg_we}, 32'h0);
        read_regs(8'h08, 2, "R1");
        read_regs(8'h03, 1, "R1");

        // R3: single write and read-back
        write_one(8'h02, 16'hA5C3, "R3");
        read_regs(8'h02, 1, "R3");

        // R2: foreign identities are ignored to the next start
        bus_start();
        send_checked(8'h90, 1'b0, "R2");
        send_checked(8'h02, 1'b0, "R2");
        send_checked(8'h11, 1'b0, "R2");
        send_checked(8'h22, 1'b0, "R2");
        bus_stop();
        bus_start();
        send_checked(8'h97, 1'b0, "R2");
        bus_stop();
        read_regs(8'h02, 1, "R2");

        // R4: multi-word write and read with auto-increment
        wbuf[0] = 16'h1111; wbuf[1] = 16'h2222; wbuf[2] = 16'h3333;
        write_words(8'h04, 3, "R4");
        read_regs(8'h04, 3, "R4");

        // R5: index held when auto-increment is off
        write_one(8'h09, 16'h0000, "R5");
        wbuf[0] = 16'hBEEF; wbuf[1] = 16'hCAFE;
        write_words(8'h0A, 2, "R5");
        read_regs(8'h0A, 2, "R5");
        write_one(8'h09, 16'h0004, "R5");

        // R7: write-only mode refuses reads, still takes writes
        write_one(8'h09, 16'h0001, "R7");
        bus_start();
        send_checked(8'h94, 1'b1, "R7");
        send_checked(8'h05, 1'b1, "R7");
        bus_start();
        send_checked(8'h95, 1'b0, "R7");
        send_checked(8'hFF, 1'b0, "R7");
        bus_stop();
        write_one(8'h09, 16'h0004, "R7");
        read_regs(8'h09, 1, "R7");

        // R8: clock guard
        sysclk_ok = 1'b0;
        write_one(8'h03, 16'h7777, "R8");
        read_regs(8'h03, 1, "R8");
        write_one(8'h08, 16'h0000, "R8");
        write_one(8'h03, 16'h7777, "R8");
        read_regs(8'h03, 1, "R8");
        write_one(8'h08, 16'h0020, "R8");
        write_one(8'h03, 16'h8888, "R8");
        sysclk_ok = 1'b1;
        read_regs(8'h03, 1, "R8");

        // R9: partial word dropped on stop, and on repeated start
        bus_start();
        send_checked(8'h94, 1'b1, "R9");
        send_checked(8'h02, 1'b1, "R9");
        send_checked(8'h55, 1'b1, "R9");
        bus_stop();
        read_regs(8'h02, 1, "R9");
        bus_start();
        send_checked(8'h94, 1'b1, "R9");
        send_checked(8'h02, 1'b1, "R9");
        send_checked(8'h66, 1'b1, "R9");
        mptr = 2;
        read_cont(1, "R9");

        // R10: indices outside the stored range
        write_one(8'h0F, 16'hF00F, "R10");
        write_one(8'h40, 16'h1234, "R10");
        read_regs(8'h40, 1, "R10");
        read_regs(8'h0F, 2, "R10");

        repeat (20) @(negedge clk);
        check(exp_addr.size() == 0, "R3", "all expected strobes seen",
              exp_addr.size(), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule